// File: doc/BRIEF.md
# Sliding Register Window Translator

This block lets a host reach a large internal register space through a small aperture. The aperture is divided into `NWIN` equal windows of `WIN_BYTES` bytes each. Every window owns a table entry with a base held in 32-bit-word units, plus an identity word. The identity word is made of a control half and a function-identity half. A host access names a window through the upper aperture address bits and an offset inside it through the lower bits. The block forms the internal byte address as base times four plus offset. It then issues the access on an internal register bus, tagged with the window's identity word, and returns the read data or an error to the host.

A configuration port is a single-cycle command strobe that is always accepted. It sets a window base directly or translates an internal address for a window, rebasing the window when the address falls outside it. It also programs the identity word: impersonate a function, impersonate a port, drop the port, or both at once. Every change to a table entry is mirrored on a table-write strobe, and a translation result comes back on its own strobe. Both strobes appear one cycle after the command.

The host request and response and the internal request and response are valid/ready channels. A payload is held stable while its valid is high and ready is low. A transfer happens on a clock edge where both are high. Only one access is in flight, so the host request ready is high only when the block is idle. The internal response is accepted only while the block waits for it.

Top module: `swin_xlat`

## Requirements
- R1: After reset every window base is invalid (all ones), all identity words are zero, and no strobe is raised. An `inv_i` pulse makes every base invalid again but keeps the identity words. A configuration command presented in the same cycle as `inv_i` is dropped: no table write and no translation result.
- R2: A host access to a window whose base is invalid gets an error response (`h_rsp_err_o`=1, `h_rsp_rdata_o`=0) and raises no internal request.
- R3: A host access to a valid window issues an internal request with address = stored base × 4 + offset. The window is aperture address bits [AP_AW-1:WIN_AW] and the offset is bits [WIN_AW-1:0]. The request carries the host's write flag and data and the window's control and function-identity words. The internal read data comes back with `h_rsp_err_o`=0.
- R4: The internal request holds its payload while stalled and the host response holds while stalled. While an internal request is pending, the host request ready and host response valid are both low.
- R5: Configuration op 0 (set base) stores argument >> 2 as the window base. It emits a table write with select 0 and data equal to that word base, unless the new base equals the stored one, in which case nothing is written.
- R6: Op 1 (translate) on an internal byte address A that is at or above the window's byte base and less than `WIN_BYTES` past it returns aperture address window × `WIN_BYTES` + (A − byte base). No table write follows.
- R7: Op 1 on an address below the byte base, `WIN_BYTES` or more past it, or on an invalid window rebases the window to A >> 2. It emits a select-0 table write and returns aperture address window × `WIN_BYTES` (offset zero).
- R8: Identity words: control bits [1:0] port, [2] use-port, [3] port-impersonate, [4] concrete, [5] function-impersonate. Function identity bits [3:0] PF number, [11:4] VF number, [12] VF-valid. Op 2 (function) sets control to 0x38, which clears any port impersonation. It sets the function identity to the argument's low 16 bits when bit 12 is set and to only bits [3:0] when it is clear.
- R9: Op 3 (port) sets control to port | use-port | port-impersonate, keeping the function identity. Op 4 (drop port) sets control to 0x08, keeping the function identity.
- R10: Op 5 (port and function) sets all five control flags with the port field and loads the function identity as in R8.
- R11: Identity ops always emit a table write with select 1 and data {function identity, control}. Ops 6 and 7 do nothing. Commands can be issued back to back, each seeing the table left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_i | input | 1 | Invalidate all window bases |
| cfg_valid_i | input | 1 | Configuration command strobe |
| cfg_op_i | input | 3 | Command code (0..5) |
| cfg_win_i | input | WSEL_W | Target window |
| cfg_arg_i | input | IADDR_W | Byte address or function identity |
| cfg_port_i | input | 2 | Port number for port ops |
| tbl_wr_o | output | 1 | Table entry written |
| tbl_wr_win_o | output | WSEL_W | Window of the table write |
| tbl_wr_sel_o | output | 1 | 0 base word, 1 identity word |
| tbl_wr_data_o | output | TW | Written value |
| xlat_valid_o | output | 1 | Translation result strobe |
| xlat_addr_o | output | AP_AW | Aperture address of the translation |
| h_req_valid_i | input | 1 | Host request valid |
| h_req_ready_o | output | 1 | Host request ready |
| h_req_addr_i | input | AP_AW | Aperture byte address |
| h_req_we_i | input | 1 | Host write flag |
| h_req_wdata_i | input | DW | Host write data |
| h_rsp_valid_o | output | 1 | Host response valid |
| h_rsp_ready_i | input | 1 | Host response ready |
| h_rsp_err_o | output | 1 | Access hit an invalid window |
| h_rsp_rdata_o | output | DW | Read data |
| i_req_valid_o | output | 1 | Internal request valid |
| i_req_ready_i | input | 1 | Internal request ready |
| i_req_addr_o | output | IADDR_W | Internal byte address |
| i_req_we_o | output | 1 | Internal write flag |
| i_req_wdata_o | output | DW | Internal write data |
| i_req_ctl_o | output | 16 | Window control word |
| i_req_fid_o | output | 16 | Window function identity |
| i_rsp_valid_i | input | 1 | Internal response valid |
| i_rsp_ready_o | output | 1 | Internal response ready |
| i_rsp_rdata_i | input | DW | Internal read data |

## Verification
The hardest situation to reach is the translate command at the very edge of a window. The last in-window word must not move the base, while the first address one window size past it, and any address one word below it, must. The stimulus gets there by rebasing a window from its invalid state and then issuing translate commands on that same window at base + size − 4, base + size and base − 4, each checked against the resulting base. A second hard case is the collision of invalidate with a configuration command in one cycle. It is driven directly, and its effect is then read back through host accesses that must now fail while keeping the identity word seen once the window is rebased.

// File: rtl/swin_pkg.sv
package swin_pkg;

  typedef enum logic [2:0] {
    OP_SETBASE = 3'd0,
    OP_XLAT    = 3'd1,
    OP_FID     = 3'd2,
    OP_PORT    = 3'd3,
    OP_UNPORT  = 3'd4,
    OP_PORTFID = 3'd5
  } cfg_op_e;

  localparam int PORT_W       = 2;
  localparam int CTL_PORT_LSB = 0;
  localparam int CTL_USEPORT  = 2;
  localparam int CTL_IMPPORT  = 3;
  localparam int CTL_CONCRETE = 4;
  localparam int CTL_IMPFUNC  = 5;

  localparam int FID_PF_W    = 4;
  localparam int FID_VFVALID = 12;

  typedef struct packed {
    logic [15:0] fid;
    logic [15:0] ctl;
  } ident_t;

  // Function identity as stored: a physical function keeps only its number.
  function automatic logic [15:0] fid_norm(input logic [15:0] f);
    return f[FID_VFVALID] ? f : {{(16-FID_PF_W){1'b0}}, f[FID_PF_W-1:0]};
  endfunction

  // Control word; every identity op keeps the port-impersonate flag set.
  function automatic logic [15:0] ctl_word(input logic use_port,
                                           input logic [PORT_W-1:0] port,
                                           input logic func);
    logic [15:0] c;
    c = '0;
    if (use_port) c[CTL_PORT_LSB +: PORT_W] = port;
    c[CTL_USEPORT]  = use_port;
    c[CTL_IMPPORT]  = 1'b1;
    c[CTL_CONCRETE] = func;
    c[CTL_IMPFUNC]  = func;
    return c;
  endfunction

endpackage

// File: rtl/swin_table.sv
module swin_table
  import swin_pkg::*;
#(
  parameter int NWIN   = 8,
  parameter int BW     = 30,
  parameter int WSEL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inv,
  input  logic                      base_we,
  input  logic [WSEL_W-1:0]         base_win,
  input  logic [BW-1:0]             base_val,
  input  logic                      id_we,
  input  logic [WSEL_W-1:0]         id_win,
  input  ident_t                    id_val,
  output logic [NWIN-1:0][BW-1:0]   base_q,
  output ident_t [NWIN-1:0]         id_q
);

  for (genvar n = 0; n < NWIN; n++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[n] <= '1;
      end else if (inv) begin
        base_q[n] <= '1;
      end else if (base_we && base_win == WSEL_W'(n)) begin
        base_q[n] <= base_val;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        id_q[n] <= '0;
      end else if (id_we && id_win == WSEL_W'(n)) begin
        id_q[n] <= id_val;
      end
    end
  end

endmodule

// File: rtl/swin_cfg.sv
module swin_cfg
  import swin_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int WIN_BYTES = 4096,
  parameter int IADDR_W   = 32,
  parameter int WSEL_W    = 3,
  parameter int WIN_AW    = 12,
  parameter int TW        = 32,
  localparam int BW       = IADDR_W - 2,
  localparam int AP_AW    = WSEL_W + WIN_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [2:0]               cmd_op,
  input  logic [WSEL_W-1:0]        cmd_win,
  input  logic [IADDR_W-1:0]       cmd_arg,
  input  logic [PORT_W-1:0]        cmd_port,
  input  logic [NWIN-1:0][BW-1:0]  base_q,
  input  ident_t [NWIN-1:0]        id_q,
  output logic                     base_we,
  output logic [BW-1:0]            base_val,
  output logic                     id_we,
  output ident_t                   id_val,
  output logic                     tbl_wr,
  output logic [WSEL_W-1:0]        tbl_win,
  output logic                     tbl_sel,
  output logic [TW-1:0]            tbl_data,
  output logic                     xl_valid,
  output logic [AP_AW-1:0]         xl_addr
);

  logic [BW-1:0]      cur_base;
  logic [15:0]        cur_fid;
  logic [IADDR_W-1:0] cur_bytes;
  logic [IADDR_W-1:0] delta;
  logic               win_ok;
  logic               in_rng;
  logic               xl_hit;
  logic [WIN_AW-1:0]  xl_off;

  assign cur_base  = base_q[cmd_win];
  assign cur_fid   = id_q[cmd_win].fid;
  assign cur_bytes = {cur_base, 2'b00};
  assign delta     = cmd_arg - cur_bytes;
  assign win_ok    = (cur_base != '1);
  assign in_rng    = win_ok && (cmd_arg >= cur_bytes) &&
                     (delta < IADDR_W'(WIN_BYTES));
  assign base_val  = cmd_arg[IADDR_W-1:2];

  always_comb begin
    base_we = 1'b0;
    id_we   = 1'b0;
    id_val  = '{fid: cur_fid, ctl: 16'h0};
    xl_hit  = 1'b0;
    xl_off  = '0;
    if (cmd_valid) begin
      case (cfg_op_e'(cmd_op))
        OP_SETBASE: base_we = !win_ok || (base_val != cur_base);
        OP_XLAT: begin
          xl_hit = 1'b1;
          if (in_rng) xl_off = delta[WIN_AW-1:0];
          else        base_we = !win_ok || (base_val != cur_base);
        end
        OP_FID: begin
          id_we  = 1'b1;
          id_val = '{fid: fid_norm(cmd_arg[15:0]), ctl: ctl_word(1'b0, '0, 1'b1)};
        end
        OP_PORT: begin
          id_we  = 1'b1;
          id_val = '{fid: cur_fid, ctl: ctl_word(1'b1, cmd_port, 1'b0)};
        end
        OP_UNPORT: begin
          id_we  = 1'b1;
          id_val = '{fid: cur_fid, ctl: ctl_word(1'b0, '0, 1'b0)};
        end
        OP_PORTFID: begin
          id_we  = 1'b1;
          id_val = '{fid: fid_norm(cmd_arg[15:0]), ctl: ctl_word(1'b1, cmd_port, 1'b1)};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbl_wr   <= 1'b0;
      tbl_win  <= '0;
      tbl_sel  <= 1'b0;
      tbl_data <= '0;
      xl_valid <= 1'b0;
      xl_addr  <= '0;
    end else begin
      tbl_wr   <= base_we || id_we;
      tbl_win  <= cmd_win;
      tbl_sel  <= id_we;
      tbl_data <= id_we ? TW'(id_val) : TW'(base_val);
      xl_valid <= xl_hit;
      xl_addr  <= {cmd_win, xl_off};
    end
  end

endmodule

// File: rtl/swin_access.sv
module swin_access
  import swin_pkg::*;
#(
  parameter int NWIN    = 8,
  parameter int IADDR_W = 32,
  parameter int DW      = 32,
  parameter int WSEL_W  = 3,
  parameter int WIN_AW  = 12,
  localparam int BW     = IADDR_W - 2,
  localparam int AP_AW  = WSEL_W + WIN_AW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWIN-1:0][BW-1:0]  base_q,
  input  ident_t [NWIN-1:0]        id_q,
  input  logic                     h_req_valid,
  output logic                     h_req_ready,
  input  logic [AP_AW-1:0]         h_req_addr,
  input  logic                     h_req_we,
  input  logic [DW-1:0]            h_req_wdata,
  output logic                     h_rsp_valid,
  input  logic                     h_rsp_ready,
  output logic                     h_rsp_err,
  output logic [DW-1:0]            h_rsp_rdata,
  output logic                     i_req_valid,
  input  logic                     i_req_ready,
  output logic [IADDR_W-1:0]       i_req_addr,
  output logic                     i_req_we,
  output logic [DW-1:0]            i_req_wdata,
  output logic [15:0]              i_req_ctl,
  output logic [15:0]              i_req_fid,
  input  logic                     i_rsp_valid,
  output logic                     i_rsp_ready,
  input  logic [DW-1:0]            i_rsp_rdata
);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_RESP} st_e;
  st_e st;

  logic [WSEL_W-1:0] wsel;
  logic [WIN_AW-1:0] woff;
  logic [BW-1:0]     sel_base;
  logic              sel_in_pool;
  logic              sel_ok;

  assign wsel     = h_req_addr[AP_AW-1:WIN_AW];
  assign woff     = h_req_addr[WIN_AW-1:0];
  assign sel_base = base_q[wsel];

  if (NWIN == (1 << WSEL_W)) begin : g_full
    assign sel_in_pool = 1'b1;
  end else begin : g_part
    assign sel_in_pool = (wsel < WSEL_W'(NWIN));
  end

  assign sel_ok      = sel_in_pool && (sel_base != '1);
  assign h_req_ready = (st == S_IDLE);
  assign i_req_valid = (st == S_ISSUE);
  assign i_rsp_ready = (st == S_WAIT);
  assign h_rsp_valid = (st == S_RESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      i_req_addr  <= '0;
      i_req_we    <= 1'b0;
      i_req_wdata <= '0;
      i_req_ctl   <= '0;
      i_req_fid   <= '0;
      h_rsp_err   <= 1'b0;
      h_rsp_rdata <= '0;
    end else begin
      case (st)
        S_IDLE: if (h_req_valid) begin
          if (sel_ok) begin
            i_req_addr  <= {sel_base, 2'b00} + IADDR_W'(woff);
            i_req_we    <= h_req_we;
            i_req_wdata <= h_req_wdata;
            i_req_ctl   <= id_q[wsel].ctl;
            i_req_fid   <= id_q[wsel].fid;
            st          <= S_ISSUE;
          end else begin
            h_rsp_err   <= 1'b1;
            h_rsp_rdata <= '0;
            st          <= S_RESP;
          end
        end
        S_ISSUE: if (i_req_ready) st <= S_WAIT;
        S_WAIT: if (i_rsp_valid) begin
          h_rsp_err   <= 1'b0;
          h_rsp_rdata <= i_rsp_rdata;
          st          <= S_RESP;
        end
        S_RESP: if (h_rsp_ready) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/swin_xlat.sv
module swin_xlat
  import swin_pkg::*;
#(
  parameter int NWIN      = 8,
  parameter int WIN_BYTES = 4096,
  parameter int IADDR_W   = 32,
  parameter int DW        = 32,
  localparam int WSEL_W   = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int WIN_AW   = $clog2(WIN_BYTES),
  localparam int AP_AW    = WSEL_W + WIN_AW,
  localparam int TW       = (IADDR_W > 34) ? IADDR_W - 2 : 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 inv_i,
  input  logic                 cfg_valid_i,
  input  logic [2:0]           cfg_op_i,
  input  logic [WSEL_W-1:0]    cfg_win_i,
  input  logic [IADDR_W-1:0]   cfg_arg_i,
  input  logic [1:0]           cfg_port_i,
  output logic                 tbl_wr_o,
  output logic [WSEL_W-1:0]    tbl_wr_win_o,
  output logic                 tbl_wr_sel_o,
  output logic [TW-1:0]        tbl_wr_data_o,
  output logic                 xlat_valid_o,
  output logic [AP_AW-1:0]     xlat_addr_o,
  input  logic                 h_req_valid_i,
  output logic                 h_req_ready_o,
  input  logic [AP_AW-1:0]     h_req_addr_i,
  input  logic                 h_req_we_i,
  input  logic [DW-1:0]        h_req_wdata_i,
  output logic                 h_rsp_valid_o,
  input  logic                 h_rsp_ready_i,
  output logic                 h_rsp_err_o,
  output logic [DW-1:0]        h_rsp_rdata_o,
  output logic                 i_req_valid_o,
  input  logic                 i_req_ready_i,
  output logic [IADDR_W-1:0]   i_req_addr_o,
  output logic                 i_req_we_o,
  output logic [DW-1:0]        i_req_wdata_o,
  output logic [15:0]          i_req_ctl_o,
  output logic [15:0]          i_req_fid_o,
  input  logic                 i_rsp_valid_i,
  output logic                 i_rsp_ready_o,
  input  logic [DW-1:0]        i_rsp_rdata_i
);

  localparam int BW = IADDR_W - 2;

  logic [NWIN-1:0][BW-1:0] base_q;
  ident_t [NWIN-1:0]       id_q;
  logic                    base_we;
  logic [BW-1:0]           base_val;
  logic                    id_we;
  ident_t                  id_val;
  logic                    cmd_valid;

  // Invalidate wins: a command in the same cycle is discarded.
  assign cmd_valid = cfg_valid_i && !inv_i;

  swin_table #(.NWIN(NWIN), .BW(BW), .WSEL_W(WSEL_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .inv      (inv_i),
    .base_we  (base_we),
    .base_win (cfg_win_i),
    .base_val (base_val),
    .id_we    (id_we),
    .id_win   (cfg_win_i),
    .id_val   (id_val),
    .base_q   (base_q),
    .id_q     (id_q)
  );

  swin_cfg #(
    .NWIN(NWIN), .WIN_BYTES(WIN_BYTES), .IADDR_W(IADDR_W),
    .WSEL_W(WSEL_W), .WIN_AW(WIN_AW), .TW(TW)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cfg_op_i),
    .cmd_win   (cfg_win_i),
    .cmd_arg   (cfg_arg_i),
    .cmd_port  (cfg_port_i),
    .base_q    (base_q),
    .id_q      (id_q),
    .base_we   (base_we),
    .base_val  (base_val),
    .id_we     (id_we),
    .id_val    (id_val),
    .tbl_wr    (tbl_wr_o),
    .tbl_win   (tbl_wr_win_o),
    .tbl_sel   (tbl_wr_sel_o),
    .tbl_data  (tbl_wr_data_o),
    .xl_valid  (xlat_valid_o),
    .xl_addr   (xlat_addr_o)
  );

  swin_access #(
    .NWIN(NWIN), .IADDR_W(IADDR_W), .DW(DW),
    .WSEL_W(WSEL_W), .WIN_AW(WIN_AW)
  ) u_access (
    .clk         (clk),
    .rst_n       (rst_n),
    .base_q      (base_q),
    .id_q        (id_q),
    .h_req_valid (h_req_valid_i),
    .h_req_ready (h_req_ready_o),
    .h_req_addr  (h_req_addr_i),
    .h_req_we    (h_req_we_i),
    .h_req_wdata (h_req_wdata_i),
    .h_rsp_valid (h_rsp_valid_o),
    .h_rsp_ready (h_rsp_ready_i),
    .h_rsp_err   (h_rsp_err_o),
    .h_rsp_rdata (h_rsp_rdata_o),
    .i_req_valid (i_req_valid_o),
    .i_req_ready (i_req_ready_i),
    .i_req_addr  (i_req_addr_o),
    .i_req_we    (i_req_we_o),
    .i_req_wdata (i_req_wdata_o),
    .i_req_ctl   (i_req_ctl_o),
    .i_req_fid   (i_req_fid_o),
    .i_rsp_valid (i_rsp_valid_i),
    .i_rsp_ready (i_rsp_ready_o),
    .i_rsp_rdata (i_rsp_rdata_i)
  );

endmodule

// File: rtl/swin_xlat_chk.sv
module swin_xlat_chk #(
  parameter int IADDR_W = 32,
  parameter int DW      = 32,
  parameter int WSEL_W  = 3,
  parameter int WIN_AW  = 12,
  parameter int TW      = 32,
  localparam int AP_AW  = WSEL_W + WIN_AW
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inv_i,
  input logic               tbl_wr_o,
  input logic               tbl_wr_sel_o,
  input logic [TW-1:0]      tbl_wr_data_o,
  input logic               xlat_valid_o,
  input logic [AP_AW-1:0]   xlat_addr_o,
  input logic               h_req_ready_o,
  input logic               h_rsp_valid_o,
  input logic               h_rsp_ready_i,
  input logic               h_rsp_err_o,
  input logic [DW-1:0]      h_rsp_rdata_o,
  input logic               i_req_valid_o,
  input logic               i_req_ready_i,
  input logic [IADDR_W-1:0] i_req_addr_o,
  input logic [15:0]        i_req_ctl_o,
  input logic [15:0]        i_req_fid_o
);

  p_ireq_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i_req_valid_o && !i_req_ready_i |=> i_req_valid_o && $stable(i_req_addr_o)
      && $stable(i_req_ctl_o) && $stable(i_req_fid_o));

  p_hrsp_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid_o && !h_rsp_ready_i |=> h_rsp_valid_o && $stable(h_rsp_err_o)
      && $stable(h_rsp_rdata_o));

  p_single_flight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i_req_valid_o |-> !h_rsp_valid_o && !h_req_ready_o);

  p_err_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    h_rsp_valid_o && h_rsp_err_o |-> h_rsp_rdata_o == '0);

  p_rebase_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_valid_o && tbl_wr_o && !tbl_wr_sel_o |-> xlat_addr_o[WIN_AW-1:0] == '0);

  p_impport_kept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr_o && tbl_wr_sel_o |-> tbl_wr_data_o[3]);

  p_inv_drops_cmd_r1: assert property (@(posedge clk) disable iff (!rst_n)
    inv_i |=> !tbl_wr_o && !xlat_valid_o);

endmodule

bind swin_xlat swin_xlat_chk #(
  .IADDR_W(IADDR_W), .DW(DW), .WSEL_W(WSEL_W), .WIN_AW(WIN_AW), .TW(TW)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .inv_i         (inv_i),
  .tbl_wr_o      (tbl_wr_o),
  .tbl_wr_sel_o  (tbl_wr_sel_o),
  .tbl_wr_data_o (tbl_wr_data_o),
  .xlat_valid_o  (xlat_valid_o),
  .xlat_addr_o   (xlat_addr_o),
  .h_req_ready_o (h_req_ready_o),
  .h_rsp_valid_o (h_rsp_valid_o),
  .h_rsp_ready_i (h_rsp_ready_i),
  .h_rsp_err_o   (h_rsp_err_o),
  .h_rsp_rdata_o (h_rsp_rdata_o),
  .i_req_valid_o (i_req_valid_o),
  .i_req_ready_i (i_req_ready_i),
  .i_req_addr_o  (i_req_addr_o),
  .i_req_ctl_o   (i_req_ctl_o),
  .i_req_fid_o   (i_req_fid_o)
);

// File: tb/swin_xlat_tb_top.sv
module swin_xlat_tb_top;

  localparam int NW = 8;
  localparam int WB = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        inv_i = 0, cfg_valid_i = 0;
  logic [2:0]  cfg_op_i = 0, cfg_win_i = 0;
  logic [31:0] cfg_arg_i = 0;
  logic [1:0]  cfg_port_i = 0;
  logic        tbl_wr_o, tbl_wr_sel_o, xlat_valid_o;
  logic [2:0]  tbl_wr_win_o;
  logic [31:0] tbl_wr_data_o;
  logic [14:0] xlat_addr_o;
  logic        h_req_valid_i = 0, h_req_ready_o, h_req_we_i = 0;
  logic [14:0] h_req_addr_i = 0;
  logic [31:0] h_req_wdata_i = 0;
  logic        h_rsp_valid_o, h_rsp_ready_i = 0, h_rsp_err_o;
  logic [31:0] h_rsp_rdata_o;
  logic        i_req_valid_o, i_req_ready_i = 0, i_req_we_o;
  logic [31:0] i_req_addr_o, i_req_wdata_o;
  logic [15:0] i_req_ctl_o, i_req_fid_o;
  logic        i_rsp_valid_i = 0, i_rsp_ready_o;
  logic [31:0] i_rsp_rdata_i = 0;

  swin_xlat dut_i (.*);

  int total = 0, bad = 0;
  bit done = 0;
  bit exp_tbl = 0, exp_ireq = 0, mon_en = 0;

  // Behavioural reference state.
  longint unsigned base_m[NW];
  bit              valid_m[NW];
  int              ctl_m[NW];
  int              fid_m[NW];

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Per-clock comparison against the model's strobe expectations.
  always @(posedge clk) begin
    #1;
    if (mon_en && !done) begin
      check("R11 table-write strobe per cycle", tbl_wr_o, exp_tbl);
      if (!exp_ireq) check("R2 no unexpected internal request", i_req_valid_o, 0);
    end
  end

  task automatic model_reset();
    for (int n = 0; n < NW; n++) begin
      valid_m[n] = 0; base_m[n] = 0; ctl_m[n] = 0; fid_m[n] = 0;
    end
  endtask

  task automatic do_cfg(input int op, input int win, input logic [31:0] arg,
                        input int port, input string tag);
    longint unsigned a, nb, cur;
    bit ewr, esel, exl, inr, usep, func;
    longint unsigned edata, exa;
    int nf, nc;
    a = arg; nb = a >> 2; cur = base_m[win] * 4;
    ewr = 0; esel = 0; exl = 0; edata = 0; exa = 0; nf = fid_m[win]; nc = 0;
    usep = 0; func = 0;
    case (op)
      0: if (!valid_m[win] || nb != base_m[win]) begin ewr = 1; edata = nb; end
      1: begin
        exl = 1;
        inr = valid_m[win] && a >= cur && (a - cur) < WB;
        if (inr) exa = win * WB + (a - cur);
        else begin
          exa = win * WB;
          if (!valid_m[win] || nb != base_m[win]) begin ewr = 1; edata = nb; end
        end
      end
      2, 3, 4, 5: begin
        ewr = 1; esel = 1;
        usep = (op == 3 || op == 5);
        func = (op == 2 || op == 5);
        if (func) nf = arg[12] ? int'(arg[15:0]) : int'(arg[3:0]);
        nc = (usep ? port : 0) + (usep ? 4 : 0) + 8 + (func ? 48 : 0);
        edata = (longint'(nf) << 16) | nc;
      end
      default: ;
    endcase
    cfg_valid_i = 1; cfg_op_i = op[2:0]; cfg_win_i = win[2:0];
    cfg_arg_i = arg; cfg_port_i = port[1:0]; exp_tbl = ewr;
    @(negedge clk);
    cfg_valid_i = 0;
    check({tag, " table write"}, tbl_wr_o, ewr);
    if (ewr) begin
      check({tag, " write select"}, tbl_wr_sel_o, esel);
      check({tag, " write window"}, tbl_wr_win_o, win);
      check({tag, " write data"}, tbl_wr_data_o, edata);
    end
    check({tag, " translate strobe"}, xlat_valid_o, exl);
    if (exl) check({tag, " aperture address"}, xlat_addr_o, exa);
    if (ewr && !esel) begin base_m[win] = nb; valid_m[win] = 1; end
    if (ewr && esel) begin ctl_m[win] = nc; fid_m[win] = nf; end
    exp_tbl = 0;
  endtask

  task automatic do_access(input int win, input int off, input bit we, input logic [31:0] wd,
                           input int istall, input logic [31:0] rd, input int rstall,
                           input string tag);
    bit ok;
    longint unsigned ea;
    ok = valid_m[win];
    ea = base_m[win] * 4 + off;
    check({tag, " R4 request ready when idle"}, h_req_ready_o, 1);
    h_req_valid_i = 1; h_req_addr_i = 15'(win * WB + off);
    h_req_we_i = we; h_req_wdata_i = wd; exp_ireq = ok;
    @(negedge clk);
    h_req_valid_i = 0;
    if (!ok) begin
      check({tag, " R2 error response"}, h_rsp_valid_o, 1);
      check({tag, " R2 error flag"}, h_rsp_err_o, 1);
      check({tag, " R2 error data"}, h_rsp_rdata_o, 0);
    end else begin
      check({tag, " R3 internal valid"}, i_req_valid_o, 1);
      check({tag, " R3 internal address"}, i_req_addr_o, ea[31:0]);
      check({tag, " R3 write flag"}, i_req_we_o, we);
      if (we) check({tag, " R3 write data"}, i_req_wdata_o, wd);
      check({tag, " R3 control word"}, i_req_ctl_o, ctl_m[win]);
      check({tag, " R3 function identity"}, i_req_fid_o, fid_m[win]);
      check({tag, " R4 ready low in flight"}, h_req_ready_o, 0);
      for (int k = 0; k < istall; k++) begin
        @(negedge clk);
        check({tag, " R4 request held"}, i_req_valid_o, 1);
        check({tag, " R4 address held"}, i_req_addr_o, ea[31:0]);
      end
      i_req_ready_i = 1;
      @(negedge clk);
      i_req_ready_i = 0;
      check({tag, " R4 request retired"}, i_req_valid_o, 0);
      exp_ireq = 0;
      check({tag, " R4 waiting for response"}, i_rsp_ready_o, 1);
      check({tag, " R4 no early response"}, h_rsp_valid_o, 0);
      i_rsp_valid_i = 1; i_rsp_rdata_i = rd;
      @(negedge clk);
      i_rsp_valid_i = 0;
      check({tag, " R3 response valid"}, h_rsp_valid_o, 1);
      check({tag, " R3 response ok"}, h_rsp_err_o, 0);
      check({tag, " R3 read data"}, h_rsp_rdata_o, rd);
    end
    for (int k = 0; k < rstall; k++) begin
      @(negedge clk);
      check({tag, " R4 response held"}, h_rsp_valid_o, 1);
    end
    h_rsp_ready_i = 1;
    @(negedge clk);
    h_rsp_ready_i = 0;
    check({tag, " R4 response retired"}, h_rsp_valid_o, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    mon_en = 1;
    // R1: reset state
    check("R1 reset idle ready", h_req_ready_o, 1);
    check("R1 reset no table write", tbl_wr_o, 0);
    check("R1 reset no translate", xlat_valid_o, 0);
    do_access(0, 'h20, 0, 0, 0, 0, 0, "R1 R2 fresh window");
    do_access(7, 'hFFC, 1, 'h55, 0, 0, 2, "R2 invalid last window");

    // R5: set base, then repeat with same word base
    do_cfg(0, 2, 32'h0001_2003, 0, "R5 set base");
    do_cfg(0, 2, 32'h0001_2001, 0, "R5 same base skipped");
    // R8: function identity with VF-valid clear
    do_cfg(2, 2, 32'h0000_0A57, 0, "R8 PF identity");
    do_access(2, 'h10, 0, 0, 2, 32'hCAFE_0001, 1, "R3 read win2");
    // R9
    do_cfg(3, 2, 0, 2, "R9 port");
    do_cfg(4, 2, 0, 0, "R9 drop port");
    do_access(2, 'hFFC, 1, 32'h1234_5678, 0, 32'h0, 0, "R3 write win2 top");
    // R10 then R8 clearing the port
    do_cfg(5, 5, 32'h0000_1345, 1, "R10 port and function");
    do_cfg(2, 5, 32'h0000_1123, 0, "R8 VF identity clears port");

    // R7/R6 window edges on win3
    do_cfg(1, 3, 32'h0004_0000, 0, "R7 rebase invalid window");
    do_cfg(1, 3, 32'h0004_0FFC, 0, "R6 last word in window");
    do_cfg(1, 3, 32'h0004_1000, 0, "R7 one window past");
    do_cfg(1, 3, 32'h0004_0FFC, 0, "R7 below base");
    do_cfg(1, 3, 32'h0004_0FFD, 0, "R6 offset within");

    // R11 back to back commands
    do_cfg(0, 6, 32'h0002_0000, 0, "R11 first of pair");
    do_cfg(1, 6, 32'h0002_0100, 0, "R11 second sees first");
    do_cfg(7, 6, 32'h0009_0000, 0, "R11 unknown op");
    do_cfg(6, 6, 32'h0009_0000, 0, "R11 unknown op six");
    do_access(6, 'h104, 1, 32'hA5A5_0F0F, 1, 32'h0, 0, "R3 write win6");

    // R1: invalidate colliding with a command
    inv_i = 1; cfg_valid_i = 1; cfg_op_i = 0; cfg_win_i = 4; cfg_arg_i = 32'h8000;
    @(negedge clk);
    inv_i = 0; cfg_valid_i = 0;
    check("R1 dropped command no write", tbl_wr_o, 0);
    check("R1 dropped command no translate", xlat_valid_o, 0);
    for (int n = 0; n < NW; n++) valid_m[n] = 0;
    do_access(2, 'h10, 0, 0, 0, 0, 0, "R1 win2 invalidated");
    do_access(4, 'h0, 0, 0, 0, 0, 0, "R1 win4 never set");
    do_cfg(0, 2, 32'h0001_2000, 0, "R1 rebase after invalidate");
    do_access(2, 'h8, 0, 0, 0, 32'h0BAD_F00D, 0, "R1 identity kept");

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule